// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Page Protection

This block caches recent virtual-to-physical page translations so that an address can be translated without walking the page table. It has a small number of entries, 128 by default, and any entry may hold any page. Every entry is compared against each lookup. An entry maps either one 8 KB base page or one 128 KB superpage. A superpage is an aligned run of 16 contiguous base pages under a single tag. Each entry also carries four permission bits: read and write, for user mode and for kernel mode. Every lookup is checked against these bits.

A lookup presents a virtual address together with the access type (read or write) and the privilege mode. One cycle later the block reports exactly one of three outcomes: a hit with the physical address, a miss, or a protection fault. After a miss, an external page-table walker supplies the translation through the refill port. The refill goes into an entry that already covers the page if there is one. Otherwise it goes into a free entry, and if none is free it evicts the least recently used entry. A single invalidate input empties the whole buffer.

Top module: `tlb_fa`

## Requirements
- R1: On a hit, bits 12:0 of `rsp_paddr` equal bits 12:0 of the looked-up `lk_vaddr`.
- R2: A lookup whose page number equals that of a valid base-page entry with the needed permission hits, and `rsp_paddr[31:13]` is that entry's physical page number.
- R3: A lookup covered by no valid entry reports `rsp_miss` with `rsp_paddr` zero. This includes addresses directly adjacent to a cached page or superpage.
- R4: Each lookup gets its response on the clock edge that follows it. While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. In a cycle after no lookup, all four are low.
- R5: A superpage entry (refilled with `rf_super`=1) matches any page number whose bits 18:4 equal its own. The physical page is the entry's bits 18:4 joined to the looked-up page number's bits 3:0.
- R6: For a superpage refill, bits 3:0 of `rf_vpn` and `rf_ppn` are ignored and treated as zero.
- R7: `rf_perm` bit 0 grants user read, bit 1 user write, bit 2 kernel read and bit 3 kernel write. A matching lookup that lacks its permission reports `rsp_fault`, with `rsp_hit` low and `rsp_paddr` zero.
- R8: When all entries are valid, a refill replaces the least recently used entry. Both refills and matching lookups count as uses.
- R9: While an invalid entry exists, a refill takes an invalid entry and evicts nothing.
- R10: A refill whose page number is already covered by a valid entry overwrites that entry in place.
- R11: After `inv_all`, every lookup misses. A refill in the same cycle as `inv_all` is dropped.
- R12: A refill takes effect on the following clock edge. A lookup in the same cycle as the refill still sees the old contents.
- R13: During reset all entries become invalid and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rf_valid | input | 1 | Refill request this cycle |
| rf_vpn | input | 19 | Virtual page number to install |
| rf_ppn | input | 19 | Physical page number to install |
| rf_super | input | 1 | 1 = 128 KB superpage entry |
| rf_perm | input | 4 | Permission bits (see R7) |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No entry covers the page |
| rsp_fault | output | 1 | Entry found but access not permitted |
| rsp_paddr | output | 32 | Physical address on hit, else zero |

## Verification
The lookup response goes through one register, so it is due on the first rising edge after the lookup is presented. The bench drives every input on a falling edge and reads the response on the next falling edge, which lies halfway after that single register stage. A refill or an invalidate changes the contents at the next rising edge. Lookups that depend on that change are therefore issued only from the following falling edge. The exception is the same-cycle case in R12, which is deliberately checked at the edge where the old contents still apply. The LRU checks fill all entries in a known order and then reason about which entry a refill must evict.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned OFS_W   = 13;  // 8 KB base page
    localparam int unsigned SUPER_W = 4;   // 16 base pages per superpage

    typedef struct packed {
        logic u_rd;
        logic u_wr;
        logic k_rd;
        logic k_wr;
    } perm_t;

    typedef enum logic [1:0] {
        RESP_NONE  = 2'd0,
        RESP_HIT   = 2'd1,
        RESP_MISS  = 2'd2,
        RESP_FAULT = 2'd3
    } resp_e;

    function automatic logic perm_allows(perm_t p, logic user, logic wr);
        logic ok;
        case ({user, wr})
            2'b10:   ok = p.u_rd;
            2'b11:   ok = p.u_wr;
            2'b00:   ok = p.k_rd;
            default: ok = p.k_wr;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned VPN_W   = 19,
    parameter int unsigned PPN_W   = 19,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inv_all,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               wr_super,
    input  perm_t              wr_perm,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [VPN_W-1:0]   rf_vpn,
    output logic               lk_any,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [PPN_W-1:0]   lk_ppn,
    output logic               lk_super,
    output perm_t              lk_perm,
    output logic               rf_any,
    output logic [IDX_W-1:0]   rf_idx,
    output logic [ENTRIES-1:0] valid_vec
);

    typedef struct packed {
        logic             valid;
        logic             sp;
        perm_t            perm;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } ent_t;

    localparam logic [VPN_W-1:0] VPN_LOW = VPN_W'((1 << SUPER_W) - 1);
    localparam logic [PPN_W-1:0] PPN_LOW = PPN_W'((1 << SUPER_W) - 1);

    ent_t               ents [ENTRIES];
    ent_t               wr_ent;
    logic [ENTRIES-1:0] lk_hit_vec;
    logic [ENTRIES-1:0] rf_hit_vec;

    function automatic logic covers(ent_t e, logic [VPN_W-1:0] v);
        logic m;
        if (e.sp)
            m = (e.vpn[VPN_W-1:SUPER_W] == v[VPN_W-1:SUPER_W]);
        else
            m = (e.vpn == v);
        return e.valid && m;
    endfunction

    // Superpage refills are forced onto an aligned boundary
    always_comb begin
        wr_ent.valid = 1'b1;
        wr_ent.sp    = wr_super;
        wr_ent.perm  = wr_perm;
        wr_ent.vpn   = wr_super ? (wr_vpn & ~VPN_LOW) : wr_vpn;
        wr_ent.ppn   = wr_super ? (wr_ppn & ~PPN_LOW) : wr_ppn;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (inv_all) begin
                ents[g].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ents[g] <= wr_ent;
            end
        end

        assign lk_hit_vec[g] = covers(ents[g], lk_vpn);
        assign rf_hit_vec[g] = covers(ents[g], rf_vpn);
        assign valid_vec[g]  = ents[g].valid;

        AST_SUPER_ALIGNED: assert property (@(posedge clk) disable iff (rst)
            (ents[g].valid && ents[g].sp) |->
                (ents[g].vpn[SUPER_W-1:0] == '0 && ents[g].ppn[SUPER_W-1:0] == '0)); // R6
    end

    // Lowest-numbered matching entry wins
    always_comb begin
        lk_any = 1'b0;
        lk_idx = '0;
        rf_any = 1'b0;
        rf_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_hit_vec[i]) begin
                lk_any = 1'b1;
                lk_idx = IDX_W'(i);
            end
            if (rf_hit_vec[i]) begin
                rf_any = 1'b1;
                rf_idx = IDX_W'(i);
            end
        end
    end

    assign lk_ppn   = ents[lk_idx].ppn;
    assign lk_super = ents[lk_idx].sp;
    assign lk_perm  = ents[lk_idx].perm;

    AST_INV_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_vec == '0)); // R11

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inv_all) |=> valid_vec[$past(wr_idx)]); // R12

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inv_all,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // Ages form a permutation of 0..ENTRIES-1; 0 is most recent
    logic [IDX_W-1:0]   age [ENTRIES];
    logic [ENTRIES-1:0] at_max;
    logic [IDX_W-1:0]   touch_age;

    assign touch_age = age[touch_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst || inv_all) begin
                age[g] <= IDX_W'(g);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(g))
                    age[g] <= '0;
                else if (age[g] < touch_age)
                    age[g] <= age[g] + 1'b1;
            end
        end
        assign at_max[g] = (age[g] == OLDEST);
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_vec[i] && !found) begin
                found      = 1'b1;
                victim_idx = IDX_W'(i);
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (at_max[i])
                    victim_idx = IDX_W'(i);
            end
        end
    end

    AST_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $countones(at_max) == 1); // R8

    AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (rst)
        (touch_en && !inv_all) |=> (age[$past(touch_idx)] == '0)); // R8

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (valid_vec != '1) |-> !valid_vec[victim_idx]); // R9

endmodule

// File: rtl/tlb_resp.sv
module tlb_resp
    import tlb_pkg::*;
#(
    parameter int unsigned PPN_W = 19,
    parameter int unsigned PA_W  = PPN_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic               lk_write,
    input  logic               lk_user,
    input  logic [OFS_W-1:0]   lk_ofs,
    input  logic [SUPER_W-1:0] lk_vpn_low,
    input  logic               match_any,
    input  logic [PPN_W-1:0]   match_ppn,
    input  logic               match_super,
    input  perm_t              match_perm,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr
);

    resp_e            kind_d, kind_q;
    logic             allowed;
    logic [PPN_W-1:0] page;
    logic [PA_W-1:0]  pa_d, pa_q;

    always_comb begin
        allowed = perm_allows(match_perm, lk_user, lk_write);
        if (!lk_valid)
            kind_d = RESP_NONE;
        else if (!match_any)
            kind_d = RESP_MISS;
        else if (!allowed)
            kind_d = RESP_FAULT;
        else
            kind_d = RESP_HIT;

        if (match_super)
            page = {match_ppn[PPN_W-1:SUPER_W], lk_vpn_low};
        else
            page = match_ppn;

        pa_d = (kind_d == RESP_HIT) ? {page, lk_ofs} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= RESP_NONE;
            pa_q   <= '0;
        end else begin
            kind_q <= kind_d;
            pa_q   <= pa_d;
        end
    end

    assign rsp_valid = (kind_q != RESP_NONE);
    assign rsp_hit   = (kind_q == RESP_HIT);
    assign rsp_miss  = (kind_q == RESP_MISS);
    assign rsp_fault = (kind_q == RESP_FAULT);
    assign rsp_paddr = pa_q;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)); // R4

    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid); // R4

    AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !match_any) |=> (rsp_miss && rsp_paddr == '0)); // R3

    AST_FAULT_BLOCKS_HIT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && match_any && !perm_allows(match_perm, lk_user, lk_write))
            |=> (rsp_fault && !rsp_hit)); // R7

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_paddr[OFS_W-1:0] == $past(lk_ofs))); // R1

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 128,
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic                  lk_write,
    input  logic                  lk_user,
    input  logic                  rf_valid,
    input  logic [VA_W-OFS_W-1:0] rf_vpn,
    input  logic [PA_W-OFS_W-1:0] rf_ppn,
    input  logic                  rf_super,
    input  logic [3:0]            rf_perm,
    input  logic                  inv_all,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic                  rsp_fault,
    output logic [PA_W-1:0]       rsp_paddr
);

    localparam int unsigned VPN_W = VA_W - OFS_W;
    localparam int unsigned PPN_W = PA_W - OFS_W;
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]   lk_vpn;
    logic [OFS_W-1:0]   lk_ofs;
    perm_t              rf_p;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic [PPN_W-1:0]   lk_ppn;
    logic               lk_super;
    perm_t              lk_perm;
    logic               rf_any;
    logic [IDX_W-1:0]   rf_idx;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;

    assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];
    assign lk_ofs = lk_vaddr[OFS_W-1:0];

    assign rf_p.u_rd = rf_perm[0];
    assign rf_p.u_wr = rf_perm[1];
    assign rf_p.k_rd = rf_perm[2];
    assign rf_p.k_wr = rf_perm[3];

    // Invalidate beats refill; an existing covering entry is reused
    assign wr_en  = rf_valid && !inv_all;
    assign wr_idx = rf_any ? rf_idx : victim_idx;

    // A refill claims the recency update over a concurrent lookup hit
    always_comb begin
        if (wr_en) begin
            touch_en  = 1'b1;
            touch_idx = wr_idx;
        end else begin
            touch_en  = lk_valid && lk_any;
            touch_idx = lk_idx;
        end
    end

    tlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .IDX_W   (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .inv_all   (inv_all),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (rf_vpn),
        .wr_ppn    (rf_ppn),
        .wr_super  (rf_super),
        .wr_perm   (rf_p),
        .lk_vpn    (lk_vpn),
        .rf_vpn    (rf_vpn),
        .lk_any    (lk_any),
        .lk_idx    (lk_idx),
        .lk_ppn    (lk_ppn),
        .lk_super  (lk_super),
        .lk_perm   (lk_perm),
        .rf_any    (rf_any),
        .rf_idx    (rf_idx),
        .valid_vec (valid_vec)
    );

    tlb_lru #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_lru (
        .clk        (clk),
        .rst        (rst),
        .inv_all    (inv_all),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    tlb_resp #(
        .PPN_W (PPN_W),
        .PA_W  (PA_W)
    ) u_resp (
        .clk         (clk),
        .rst         (rst),
        .lk_valid    (lk_valid),
        .lk_write    (lk_write),
        .lk_user     (lk_user),
        .lk_ofs      (lk_ofs),
        .lk_vpn_low  (lk_vpn[SUPER_W-1:0]),
        .match_any   (lk_any),
        .match_ppn   (lk_ppn),
        .match_super (lk_super),
        .match_perm  (lk_perm),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_miss    (rsp_miss),
        .rsp_fault   (rsp_fault),
        .rsp_paddr   (rsp_paddr)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_valid && rsp_paddr == '0)); // R13

endmodule

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic        lk_write;
    logic        lk_user;
    logic        rf_valid;
    logic [18:0] rf_vpn;
    logic [18:0] rf_ppn;
    logic        rf_super;
    logic [3:0]  rf_perm;
    logic        inv_all;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_miss;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tlb_fa dut (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lk_valid),
        .lk_vaddr  (lk_vaddr),
        .lk_write  (lk_write),
        .lk_user   (lk_user),
        .rf_valid  (rf_valid),
        .rf_vpn    (rf_vpn),
        .rf_ppn    (rf_ppn),
        .rf_super  (rf_super),
        .rf_perm   (rf_perm),
        .inv_all   (inv_all),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_fault (rsp_fault),
        .rsp_paddr (rsp_paddr)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic        ehit;
        logic        efault;
        logic [31:0] epa;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{{19'h00010, 13'h0123}, 1'b0, 1'b1, 1'b1, 1'b0, {19'h00AB0, 13'h0123}, 4'd2}, // R2
        '{{19'h00010, 13'h1FFF}, 1'b1, 1'b1, 1'b1, 1'b0, {19'h00AB0, 13'h1FFF}, 4'd1}, // R1
        '{{19'h0002A, 13'h0456}, 1'b0, 1'b1, 1'b1, 1'b0, {19'h0055A, 13'h0456}, 4'd5}, // R5
        '{{19'h0002F, 13'h0000}, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0,                  4'd7}, // R7
        '{{19'h0002F, 13'h0ABC}, 1'b1, 1'b0, 1'b1, 1'b0, {19'h0055F, 13'h0ABC}, 4'd5}, // R5
        '{{19'h00030, 13'h0010}, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0,                  4'd7}, // R7
        '{{19'h00030, 13'h0010}, 1'b1, 1'b0, 1'b1, 1'b0, {19'h00777, 13'h0010}, 4'd7}, // R7
        '{{19'h00011, 13'h0000}, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,                  4'd3}, // R3
        '{{19'h00031, 13'h0000}, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,                  4'd3}, // R3
        '{{19'h0001F, 13'h1234}, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,                  4'd3}, // R3
        '{{19'h00020, 13'h0000}, 1'b0, 1'b1, 1'b1, 1'b0, {19'h00550, 13'h0000}, 4'd6}  // R6
    };

    task automatic check_rsp(string tag, logic eh, logic ef, logic [31:0] ep);
        logic em;
        em = !eh && !ef;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_fault !== ef ||
            rsp_miss !== em || rsp_paddr !== ep) begin
            fails++;
            $display("FAIL %s: got v=%b h=%b m=%b f=%b pa=%h, expected v=1 h=%b m=%b f=%b pa=%h",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr, eh, em, ef, ep);
        end
    endtask

    task automatic check_idle(string tag);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0 ||
            rsp_fault !== 1'b0 || rsp_paddr !== 32'h0) begin
            fails++;
            $display("FAIL %s: got v=%b h=%b m=%b f=%b pa=%h, expected all zero",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr);
        end
    endtask

    task automatic refill(logic [18:0] vpn, logic [18:0] ppn, logic sp, logic [3:0] perm);
        @(negedge clk);
        rf_valid = 1'b1;
        rf_vpn   = vpn;
        rf_ppn   = ppn;
        rf_super = sp;
        rf_perm  = perm;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    // Presents a lookup on a falling edge; response is sampled one falling edge later
    task automatic lookup(logic [31:0] va, logic wr, logic usr);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        lk_write = wr;
        lk_user  = usr;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        rst      = 1'b1;
        lk_valid = 1'b0;
        lk_vaddr = '0;
        lk_write = 1'b0;
        lk_user  = 1'b0;
        rf_valid = 1'b0;
        rf_vpn   = '0;
        rf_ppn   = '0;
        rf_super = 1'b0;
        rf_perm  = '0;
        inv_all  = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R13 reset outputs");
        rst = 1'b0;

        lookup({19'h00010, 13'h0}, 1'b0, 1'b0);
        check_rsp("R13 empty after reset", 1'b0, 1'b0, 32'h0);

        refill(19'h00010, 19'h00AB0, 1'b0, 4'b1111);
        refill(19'h00023, 19'h0055F, 1'b1, 4'b1101);   // unaligned superpage, R6
        refill(19'h00030, 19'h00777, 1'b0, 4'b1100);

        for (int i = 0; i < NVEC; i++) begin
            lookup(VEC[i].va, VEC[i].wr, VEC[i].usr);
            check_rsp($sformatf("R%0d vector %0d", VEC[i].req, i),
                      VEC[i].ehit, VEC[i].efault, VEC[i].epa);
        end

        // R4: no lookup, no response
        @(negedge clk);
        check_idle("R4 idle cycle");

        // R12: refill and lookup in the same cycle
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = 19'h00040; rf_ppn = 19'h01234; rf_super = 1'b0; rf_perm = 4'b1111;
        lk_valid = 1'b1; lk_vaddr = {19'h00040, 13'h0042}; lk_write = 1'b0; lk_user = 1'b1;
        @(negedge clk);
        rf_valid = 1'b0; lk_valid = 1'b0;
        check_rsp("R12 same-cycle lookup sees old", 1'b0, 1'b0, 32'h0);
        lookup({19'h00040, 13'h0042}, 1'b0, 1'b1);
        check_rsp("R12 following lookup hits", 1'b1, 1'b0, {19'h01234, 13'h0042});

        // R10: overwrite in place
        refill(19'h00010, 19'h00BBB, 1'b0, 4'b0001);
        lookup({19'h00010, 13'h0005}, 1'b0, 1'b1);
        check_rsp("R10 new translation", 1'b1, 1'b0, {19'h00BBB, 13'h0005});
        lookup({19'h00010, 13'h0005}, 1'b1, 1'b1);
        check_rsp("R10 new permissions", 1'b0, 1'b1, 32'h0);

        // R11: invalidate all
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        lookup({19'h00030, 13'h0}, 1'b0, 1'b0);
        check_rsp("R11 miss after invalidate", 1'b0, 1'b0, 32'h0);
        lookup({19'h00040, 13'h0}, 1'b0, 1'b1);
        check_rsp("R11 miss after invalidate", 1'b0, 1'b0, 32'h0);

        // R9: fill every entry, nothing evicted
        for (int i = 0; i < 128; i++)
            refill(19'h00100 + 19'(i), 19'h02000 + 19'(i), 1'b0, 4'b1111);
        for (int i = 0; i < 128; i++) begin
            lookup({19'h00100 + 19'(i), 13'h0007}, 1'b0, 1'b0);
            check_rsp($sformatf("R9 entry %0d kept", i), 1'b1, 1'b0, {19'h02000 + 19'(i), 13'h0007});
        end

        // R8: lookups above touched 0x100..0x17F in order; touch 0x100 again
        lookup({19'h00100, 13'h0}, 1'b0, 1'b0);
        check_rsp("R8 touch oldest", 1'b1, 1'b0, {19'h02000, 13'h0});
        refill(19'h00900, 19'h03000, 1'b0, 4'b1111);
        lookup({19'h00101, 13'h0}, 1'b0, 1'b0);
        check_rsp("R8 LRU evicted", 1'b0, 1'b0, 32'h0);
        lookup({19'h00100, 13'h0}, 1'b0, 1'b0);
        check_rsp("R8 recent kept", 1'b1, 1'b0, {19'h02000, 13'h0});
        lookup({19'h00900, 13'h0}, 1'b0, 1'b0);
        check_rsp("R8 new entry", 1'b1, 1'b0, {19'h03000, 13'h0});
        refill(19'h00901, 19'h03001, 1'b0, 4'b1111);
        lookup({19'h00102, 13'h0}, 1'b0, 1'b0);
        check_rsp("R8 next LRU evicted", 1'b0, 1'b0, 32'h0);
        lookup({19'h00103, 13'h0}, 1'b0, 1'b0);
        check_rsp("R8 neighbour kept", 1'b1, 1'b0, {19'h02003, 13'h0});

        // R11: refill together with invalidate is dropped
        @(negedge clk);
        inv_all = 1'b1;
        rf_valid = 1'b1; rf_vpn = 19'h00950; rf_ppn = 19'h00001; rf_super = 1'b0; rf_perm = 4'b1111;
        @(negedge clk);
        inv_all = 1'b0; rf_valid = 1'b0;
        lookup({19'h00950, 13'h0}, 1'b0, 1'b0);
        check_rsp("R11 refill dropped", 1'b0, 1'b0, 32'h0);
        lookup({19'h00103, 13'h0}, 1'b0, 1'b0);
        check_rsp("R11 old entry gone", 1'b0, 1'b0, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule